// File: doc/BRIEF.md
# SD Card SPI-Mode Command Engine

This block runs one complete command exchange with a memory card wired in SPI mode. A caller pulses `start` together with a 6-bit command index and a 32-bit argument. The engine then lowers chip-select and sends a six-byte command frame through a byte-level SPI master. It keeps clocking filler bytes until the card returns a status byte with its top bit clear, and finishes with one more filler byte after chip-select has gone high again. The status byte, or a timeout indication, is handed back with a one-cycle `done` pulse.

The SPI master attached below the engine works one byte at a time. The engine raises `spi_start` for one cycle with the byte on `spi_tx`. The master later raises `spi_done` for one cycle with the byte it received on `spi_rx`. The engine never starts a new byte before the current one has completed. The status byte is returned raw: bit 0 marks a card that is still initialising, bit 2 an illegal command, bits 1 and 3 to 6 the remaining error flags, and bit 7 is always zero in a valid status byte.

Top module: `sd_cmd_engine`

## Requirements
- R1: The first frame byte sent is 0x40 OR the command index, so its bits 7:6 are 01 and bits 5:0 hold the index.
- R2: Frame bytes 2 to 5 carry the argument, most significant byte first.
- R3: Frame byte 6 is always 0xA5 XOR 0x30 (that is 0x95), whatever the command or argument.
- R4: `cs_n` is high in reset and while idle. It is low for every frame byte and every polling byte of a command.
- R5: After the frame, every byte sent is 0xFF. The first received polling byte with bit 7 clear is returned on `resp`. Bytes received while the frame itself is being sent are ignored, even if their bit 7 is clear.
- R6: If POLL_LIMIT (default 5000) polling bytes all arrive with bit 7 set, polling stops after exactly that many bytes, `timeout` is 1 and `resp` is 0xFF. A valid reply on the last allowed poll still counts as success with `timeout` 0.
- R7: After a reply or a timeout, exactly one more 0xFF byte is sent with `cs_n` already high. The byte received for it does not change `resp`.
- R8: `done` is a single-cycle pulse in the cycle after the trailing byte completes. `resp` and `timeout` then stay unchanged until the next accepted start, and `busy` is high from acceptance until `done`.
- R9: A `start` pulse that arrives while `busy` is high is ignored. The running command's bytes and byte count are unchanged.
- R10: After reset, `cs_n`=1, `busy`=0, `done`=0, `spi_start`=0, `timeout`=0 and `resp`=0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse; accepted only while idle |
| cmd_idx | input | 6 | Command index, sampled on accepted start |
| cmd_arg | input | 32 | Command argument, sampled on accepted start |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle completion pulse |
| resp | output | 8 | Returned status byte (0xFF after timeout) |
| timeout | output | 1 | No valid status byte within the poll budget |
| cs_n | output | 1 | Card chip-select, active low |
| spi_start | output | 1 | Launch one byte on the SPI master |
| spi_tx | output | 8 | Byte to send |
| spi_done | input | 1 | The launched byte has completed |
| spi_rx | input | 8 | Byte received during that transfer |

## Verification
The hardest condition to reach is the poll budget boundary. It needs a card that stays silent for thousands of bytes, and the reply must land exactly on the final permitted poll or one byte beyond it. The bench's card model is told how many 0xFF bytes to return before its status byte. It is run with a delay of POLL_LIMIT-1, which must succeed, and with a delay of POLL_LIMIT, which must time out. The same model answers frame bytes with 0x00 and the trailing byte with 0x3C. This shows that replies arriving outside the polling window are ignored.

// File: rtl/sd_cmd_pkg.sv
package sd_cmd_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT} eng_state_t;
  typedef enum logic [1:0] {PH_FRAME, PH_POLL, PH_TRAIL} eng_phase_t;

  localparam int unsigned FRAME_BYTES = 6;
  localparam logic [7:0]  FILL_BYTE   = 8'hFF;

  // Select one byte of the command frame by position.
  function automatic logic [7:0] frame_byte(input logic [2:0]  pos,
                                            input logic [5:0]  idx,
                                            input logic [31:0] arg,
                                            input logic [7:0]  crc);
    logic [7:0] b;
    case (pos)
      3'd0:    b = {2'b01, idx};
      3'd1:    b = arg[31:24];
      3'd2:    b = arg[23:16];
      3'd3:    b = arg[15:8];
      3'd4:    b = arg[7:0];
      3'd5:    b = crc;
      default: b = FILL_BYTE;
    endcase
    return b;
  endfunction

  // A status byte is recognised by a clear top bit.
  function automatic logic is_status(input logic [7:0] b);
    return ~b[7];
  endfunction

endpackage

// File: rtl/sd_poll_counter.sv
module sd_poll_counter #(
  parameter int unsigned LIMIT = 5000,
  parameter int unsigned CW    = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] count,
  output logic          last
);
  always_ff @(posedge clk) begin
    if (!rst_n)   count <= '0;
    else if (clr) count <= '0;
    else if (inc) count <= count + 1'b1;
  end

  // High while the poll now running is the final one in the budget.
  assign last = (count == CW'(LIMIT - 1));
endmodule

// File: rtl/sd_frame_builder.sv
module sd_frame_builder
  import sd_cmd_pkg::*;
#(
  parameter logic [7:0] CRC_BYTE = 8'h95
) (
  input  eng_phase_t  phase,
  input  logic [2:0]  pos,
  input  logic [5:0]  idx,
  input  logic [31:0] arg,
  output logic [7:0]  tx_byte
);
  always_comb begin
    if (phase == PH_FRAME) tx_byte = frame_byte(pos, idx, arg, CRC_BYTE);
    else                   tx_byte = FILL_BYTE;
  end
endmodule

// File: rtl/sd_cmd_engine.sv
module sd_cmd_engine
  import sd_cmd_pkg::*;
#(
  parameter int unsigned POLL_LIMIT = 5000,
  parameter logic [7:0]  CRC_BYTE   = 8'h95
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [5:0]  cmd_idx,
  input  logic [31:0] cmd_arg,
  output logic        busy,
  output logic        done,
  output logic [7:0]  resp,
  output logic        timeout,
  output logic        cs_n,
  output logic        spi_start,
  output logic [7:0]  spi_tx,
  input  logic        spi_done,
  input  logic [7:0]  spi_rx
);
  localparam int unsigned CNT_W    = $clog2(POLL_LIMIT + 1);
  localparam logic [2:0]  LAST_POS = 3'(FRAME_BYTES - 1);

  eng_state_t  state_q;
  eng_phase_t  phase_q;
  logic [2:0]  pos_q;
  logic [5:0]  idx_q;
  logic [31:0] arg_q;
  logic        cs_q, done_q, tout_q;
  logic [7:0]  resp_q;

  // Named events used by the logic and by the checker.
  logic             accept, xfer_end, in_poll, in_trail, reply_hit, give_up, poll_last;
  logic [CNT_W-1:0] poll_count;

  assign accept    = start && (state_q == ST_IDLE);
  assign xfer_end  = (state_q == ST_WAIT) && spi_done;
  assign in_poll   = (phase_q == PH_POLL);
  assign in_trail  = (phase_q == PH_TRAIL);
  assign reply_hit = xfer_end && in_poll && is_status(spi_rx);
  assign give_up   = xfer_end && in_poll && !is_status(spi_rx) && poll_last;

  sd_poll_counter #(.LIMIT(POLL_LIMIT), .CW(CNT_W)) u_poll (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (accept),
    .inc   (xfer_end && in_poll),
    .count (poll_count),
    .last  (poll_last)
  );

  sd_frame_builder #(.CRC_BYTE(CRC_BYTE)) u_frame (
    .phase   (phase_q),
    .pos     (pos_q),
    .idx     (idx_q),
    .arg     (arg_q),
    .tx_byte (spi_tx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      phase_q <= PH_FRAME;
      pos_q   <= '0;
      idx_q   <= '0;
      arg_q   <= '0;
      cs_q    <= 1'b1;
      done_q  <= 1'b0;
      tout_q  <= 1'b0;
      resp_q  <= FILL_BYTE;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            idx_q   <= cmd_idx;
            arg_q   <= cmd_arg;
            phase_q <= PH_FRAME;
            pos_q   <= '0;
            cs_q    <= 1'b0;
            state_q <= ST_ISSUE;
          end
        end
        ST_ISSUE: state_q <= ST_WAIT;
        ST_WAIT: begin
          if (xfer_end) begin
            state_q <= ST_ISSUE;
            case (phase_q)
              PH_FRAME: begin
                if (pos_q == LAST_POS) phase_q <= PH_POLL;
                else                   pos_q   <= pos_q + 1'b1;
              end
              PH_POLL: begin
                if (reply_hit) begin
                  resp_q  <= spi_rx;
                  tout_q  <= 1'b0;
                  cs_q    <= 1'b1;
                  phase_q <= PH_TRAIL;
                end else if (give_up) begin
                  resp_q  <= FILL_BYTE;
                  tout_q  <= 1'b1;
                  cs_q    <= 1'b1;
                  phase_q <= PH_TRAIL;
                end
              end
              default: begin
                done_q  <= 1'b1;
                state_q <= ST_IDLE;
              end
            endcase
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign done      = done_q;
  assign resp      = resp_q;
  assign timeout   = tout_q;
  assign cs_n      = cs_q;
  assign spi_start = (state_q == ST_ISSUE);
endmodule

// File: rtl/sd_cmd_engine_chk.sv
module sd_cmd_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic [7:0]  resp,
  input logic        timeout,
  input logic        cs_n,
  input logic        spi_start,
  input logic [7:0]  spi_tx,
  input logic        in_poll,
  input logic [5:0]  idx_q,
  input logic [31:0] arg_q
);
  p_cs_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> cs_n);

  p_cs_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !cs_n);

  p_poll_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_start && in_poll) |-> (spi_tx == 8'hFF));

  p_tout_resp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && timeout) |-> (resp == 8'hFF));

  p_trail_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_start && cs_n) |-> (spi_tx == 8'hFF));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(resp) && $stable(timeout)));

  p_one_byte_r8: assert property (@(posedge clk) disable iff (!rst_n)
    spi_start |=> !spi_start);

  p_busy_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(idx_q) && $stable(arg_q)));
endmodule

bind sd_cmd_engine sd_cmd_engine_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .resp      (resp),
  .timeout   (timeout),
  .cs_n      (cs_n),
  .spi_start (spi_start),
  .spi_tx    (spi_tx),
  .in_poll   (in_poll),
  .idx_q     (idx_q),
  .arg_q     (arg_q)
);

// File: tb/tb_sd_cmd_engine.sv
module tb_sd_cmd_engine;
  localparam int LIMIT = 5000;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [5:0] cmd_idx = '0;
  logic [31:0] cmd_arg = '0;
  logic busy, done, timeout, cs_n, spi_start;
  logic [7:0] resp, spi_tx;
  logic spi_done = 1'b0;
  logic [7:0] spi_rx = 8'h00;

  always #2 clk = ~clk;

  sd_cmd_engine dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_idx(cmd_idx), .cmd_arg(cmd_arg),
    .busy(busy), .done(done), .resp(resp), .timeout(timeout), .cs_n(cs_n),
    .spi_start(spi_start), .spi_tx(spi_tx), .spi_done(spi_done), .spi_rx(spi_rx)
  );

  int checks = 0, errors = 0, cycles = 0;
  bit finished = 0;

  // Card / SPI master model state
  logic [7:0] tx_log[$];
  bit         cs_log[$];
  int  nbytes = 0, card_delay = 0, wait_cnt = 0;
  logic [7:0] card_resp = 8'h01;
  bit  pend = 0;
  logic [7:0] pend_rx;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] card_answer(input int n);
    int p;
    if (n < 6) return 8'h00;            // replies during the frame must be ignored
    p = n - 6;
    if (p < card_delay)  return 8'hFF;
    if (p == card_delay) return card_resp;
    return 8'h3C;                        // trailing byte reply, must be ignored
  endfunction

  always @(negedge clk) begin
    cycles++;
    spi_done = 1'b0;
    if (!rst_n) begin
      pend = 0;
    end else begin
      // per-clock comparison against the model
      chk(!(spi_start && pend), "R8 overlapping byte", 1, 0);
      chk(busy || cs_n, "R4 cs_n while idle", cs_n, 1);
      if (pend) begin
        if (wait_cnt == 0) begin
          spi_done = 1'b1;
          spi_rx   = pend_rx;
          pend     = 0;
        end else wait_cnt--;
      end
      if (spi_start) begin
        tx_log.push_back(spi_tx);
        cs_log.push_back(cs_n);
        pend_rx  = card_answer(nbytes);
        wait_cnt = nbytes % 3;
        pend     = 1;
        nbytes++;
      end
    end
  end

  task automatic run_cmd(input logic [5:0] idx, input logic [31:0] arg,
                         input int delay, input logic [7:0] r1, input bit inject);
    int polls, total, guard;
    bit exp_to;
    logic [7:0] exp_resp;
    logic [7:0] e;
    tx_log.delete(); cs_log.delete();
    nbytes = 0; card_delay = delay; card_resp = r1;
    @(negedge clk);
    start = 1; cmd_idx = idx; cmd_arg = arg;
    @(negedge clk);
    start = 0; cmd_idx = ~idx; cmd_arg = ~arg;
    chk(busy === 1'b1, "R8 busy after start", busy, 1);
    guard = 0;
    while (done !== 1'b1 && guard < 40000) begin
      @(negedge clk);
      guard++;
      if (inject && guard == 12) start = 1;
      if (inject && guard == 13) start = 0;
    end
    if (guard >= 40000) begin
      chk(0, "R8 done never seen", 0, 1);
      return;
    end
    exp_to   = (delay >= LIMIT);
    polls    = exp_to ? LIMIT : delay + 1;
    total    = 6 + polls + 1;
    exp_resp = exp_to ? 8'hFF : r1;
    chk(tx_log.size() == total, inject ? "R9 byte count" : "R6 byte count", tx_log.size(), total);
    if (tx_log.size() == total) begin
      chk(tx_log[0] == (8'h40 | idx), "R1 lead byte", tx_log[0], 8'h40 | idx);
      for (int k = 1; k < 5; k++) begin
        e = arg[8*(4-k) +: 8];
        chk(tx_log[k] == e, "R2 arg byte", tx_log[k], e);
      end
      chk(tx_log[5] == 8'h95, "R3 crc byte", tx_log[5], 8'h95);
      for (int k = 0; k < total - 1; k++)
        chk(cs_log[k] == 1'b0, "R4 cs low during frame/poll", cs_log[k], 0);
      for (int k = 6; k < total; k++)
        chk(tx_log[k] == 8'hFF, "R5 poll fill", tx_log[k], 8'hFF);
      chk(cs_log[total-1] == 1'b1, "R7 trailing byte cs high", cs_log[total-1], 1);
    end
    chk(timeout == exp_to, "R6 timeout flag", timeout, exp_to);
    chk(resp == exp_resp, "R5 R7 status byte", resp, exp_resp);
    @(negedge clk);
    chk(done == 1'b0, "R8 done single pulse", done, 0);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(resp == exp_resp && timeout == exp_to && !busy && cs_n, "R8 hold after done", resp, exp_resp);
    end
  endtask

  always @(negedge clk) begin
    if (cycles > 190000 && !finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected=<190000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(cs_n == 1 && busy == 0 && done == 0 && spi_start == 0, "R10 reset controls", {cs_n, busy, done, spi_start}, 4'b1000);
    chk(timeout == 0 && resp == 8'hFF, "R10 reset outputs", resp, 8'hFF);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run_cmd(6'd0,  32'h0000_0000, 0,  8'h01, 0);   // immediate idle reply
    run_cmd(6'd17, 32'h1234_5678, 3,  8'h00, 0);   // few busy polls
    run_cmd(6'd63, 32'hA5C3_0F81, 9,  8'h04, 1);   // illegal command flag, start injected (R9)
    run_cmd(6'd41, 32'hFFFF_0001, LIMIT - 1, 8'h7E, 0);  // reply on the last allowed poll
    run_cmd(6'd55, 32'h8000_0000, LIMIT, 8'h00, 0);      // timeout
    run_cmd(6'd16, 32'h0000_0200, 1,  8'h00, 0);   // recovery after timeout
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule